// File: doc/BRIEF.md
# Value-Indexed Occupancy Sorter

This block sorts a batch of unsigned bytes without comparing any two of them. It has a table with one small counter for every possible input value. Each accepted byte is used directly as the table address, and the counter at that address is raised. When the producer flags the final byte of a batch, the block walks the table from the lowest address to the highest. Each time an entry is nonzero, it puts that address on the output. The result is the batch in ascending order.

The counter width is a parameter, and it selects the behaviour. With one bit per entry, the table records only whether a value was seen, so a value sent more than once comes out once. With three bits per entry, the table counts repeats, so each value comes out as many times as it arrived, up to a limit of seven. After reset the table is wiped one entry per cycle before the first byte is taken. The sweep empties every entry as it reads it, so a new batch can start as soon as the sweep ends. There is no output backpressure: a result is presented for exactly one cycle.

Top module: `occsort_top`

## Requirements
- R1: While `rst_n` is low and during the wipe that follows its release, `in_ready`, `out_valid` and `done` are low. The release takes two cycles to resynchronise and the wipe takes one cycle per table entry, so with 8-bit data `in_ready` first reads high 258 cycles after `rst_n` rises.
- R2: A byte is taken only on a cycle where `in_valid` and `in_ready` are both high. Bytes offered during reset, during the wipe or during a sweep leave no trace in any later output.
- R3: While `in_ready` is high, an accepted byte raises the table entry addressed by its value. An accepted byte with `in_last` high ends the batch: `in_ready` drops on the next cycle and the sweep begins.
- R4: Outputs are registered. The sweep visits addresses 0 to 255 in ascending order. An empty address takes one cycle and gives no output. A nonzero address gives one output cycle (`out_valid` high, `out_data` equal to the address) per stored copy. The first sweep step becomes visible one cycle after the cycle in which `in_ready` drops.
- R5: With `CNT_W` = 1, a value received any number of times in a batch is emitted exactly once.
- R6: With `CNT_W` = 3, a value is emitted as many times as it was received, saturating at 7 copies. The count does not wrap.
- R7: `done` is high for exactly one cycle, on the cycle that shows the result of the last step at address 255. `in_ready` is high again on that same cycle.
- R8: After a sweep the table is empty. The next batch starts with no new wipe and emits only its own bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input byte is present |
| in_data | input | DATA_W | Input byte |
| in_last | input | 1 | Marks the final byte of the batch; starts the sweep |
| in_ready | output | 1 | Block is collecting bytes |
| out_valid | output | 1 | Sorted byte is present this cycle |
| out_data | output | DATA_W | Sorted byte |
| done | output | 1 | One-cycle pulse at the end of the sweep |

## Verification
A bad table entry shows up during the sweep of the same batch or of the next one. A stale or extra entry adds an output; a lost or wrapped count removes outputs. An error in the pointer or the repeat logic shows up as outputs out of order, or as the wrong number of repeats in a run. Because every cycle of the sweep has a known expected value, any such fault also moves the cycle of `done` and of the later outputs. A wrong state shows up as `in_ready` taking the wrong value on the very next cycle.

// File: rtl/occsort_pkg.sv
package occsort_pkg;
  typedef enum logic [1:0] {
    ST_WIPE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_SWEEP = 2'd2
  } occ_state_e;
endpackage

// File: rtl/occsort_rstsync.sv
module occsort_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/occsort_table.sv
module occsort_table #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CNT_W-1:0] row [DEPTH];

  // One register slot per value; contents are wiped by the controller, not by reset.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [CNT_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr == ADDR_W'(g))) begin
        slot_q <= wr_data;
      end
    end
    assign row[g] = slot_q;
  end

  assign rd_data = row[rd_addr];
endmodule

// File: rtl/occsort_ctrl.sv
module occsort_ctrl
  import occsort_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_data,
  input  logic              in_last,
  input  logic [CNT_W-1:0]  rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [CNT_W-1:0]  wr_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_data,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;
  localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

  occ_state_e        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              out_valid_q, emit_d;
  logic              done_q, done_d;
  logic [ADDR_W-1:0] out_data_q;

  always_comb begin
    state_d  = state_q;
    ptr_d    = ptr_q;
    rd_addr  = ptr_q;
    wr_en    = 1'b0;
    wr_addr  = ptr_q;
    wr_data  = '0;
    in_ready = 1'b0;
    emit_d   = 1'b0;
    done_d   = 1'b0;
    unique case (state_q)
      ST_WIPE: begin
        wr_en = 1'b1;
        ptr_d = ptr_q + 1'b1;
        if (ptr_q == LAST_ADDR) state_d = ST_FILL;
      end
      ST_FILL: begin
        in_ready = 1'b1;
        rd_addr  = in_data;
        wr_addr  = in_data;
        if (in_valid) begin
          wr_en   = 1'b1;
          wr_data = (rd_data == CNT_MAX) ? rd_data : rd_data + 1'b1;
          if (in_last) begin
            state_d = ST_SWEEP;
            ptr_d   = '0;
          end
        end
      end
      ST_SWEEP: begin
        if (rd_data != '0) begin
          emit_d  = 1'b1;
          wr_en   = 1'b1;
          wr_data = rd_data - 1'b1;
        end
        if (rd_data <= CNT_ONE) begin
          ptr_d = ptr_q + 1'b1;
          if (ptr_q == LAST_ADDR) begin
            done_d  = 1'b1;
            state_d = ST_FILL;
          end
        end
      end
      default: state_d = ST_WIPE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_WIPE;
      ptr_q       <= '0;
      out_valid_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      ptr_q       <= ptr_d;
      out_valid_q <= emit_d;
      done_q      <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (emit_d) out_data_q <= ptr_q;
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign done      = done_q;
endmodule

// File: rtl/occsort_top.sv
module occsort_top #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              done
);
  logic              rst_sync_n;
  logic [DATA_W-1:0] rd_addr, wr_addr;
  logic [CNT_W-1:0]  rd_data, wr_data;
  logic              wr_en;

  occsort_rstsync u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  occsort_table #(.ADDR_W(DATA_W), .CNT_W(CNT_W)) u_table (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  occsort_ctrl #(.ADDR_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .done      (done)
  );
endmodule

// File: rtl/occsort_chk.sv
module occsort_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_last,
  input logic              in_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              done
);
  localparam logic [CNT_W:0] RUN_CAP = (CNT_W+1)'((1 << CNT_W) - 1);

  logic              seen_q;
  logic [DATA_W-1:0] prev_q;
  logic [CNT_W:0]    run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      prev_q <= '0;
      run_q  <= '0;
    end else begin
      if (out_valid) begin
        prev_q <= out_data;
        run_q  <= (seen_q && out_data == prev_q) ? run_q + 1'b1 : (CNT_W+1)'(1);
      end
      seen_q <= done ? 1'b0 : (seen_q | out_valid);
    end
  end

  assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen_q) |-> (out_data >= prev_q));

  assert_out_after_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$past(in_ready));

  assert_ready_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !(in_valid && in_last)) |=> in_ready);

  assert_run_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen_q && out_data == prev_q) |-> (run_q < RUN_CAP));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  if (CNT_W == 1) begin : g_presence
    assert_unique_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && seen_q) |-> (out_data != prev_q));
  end
endmodule

bind occsort_top occsort_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_last   (in_last),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .done      (done)
);

// File: tb/occsort_top_tb.sv
`timescale 1ns/1ps
module occsort_top_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, in_valid, in_last;
  logic [7:0] in_data;
  logic       rdy [2];
  logic       ov  [2];
  logic       dn  [2];
  logic [7:0] od  [2];

  // index 0: counted mode (3-bit), index 1: presence mode (1-bit)
  occsort_top #(.DATA_W(8), .CNT_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(rdy[0]), .out_valid(ov[0]), .out_data(od[0]), .done(dn[0]));
  occsort_top #(.DATA_W(8), .CNT_W(1)) u_dut_pres (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(rdy[1]), .out_valid(ov[1]), .out_data(od[1]), .done(dn[1]));

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    rel = 1'b0;
  bit    finished = 1'b0;
  string batch_tag = "R4";
  int    cnt [2][256];
  int    q0 [$];
  int    q1 [$];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic void push(int m, int e);
    if (m == 0) q0.push_back(e); else q1.push_back(e);
  endfunction

  // Expected per-cycle output stream: bit10 valid, bit9 done, low byte data.
  function automatic void build(int m);
    push(m, 0);  // cycle in which the sweep state is entered
    for (int a = 0; a < 256; a++) begin
      int c = cnt[m][a];
      cnt[m][a] = 0;
      if (c == 0) push(m, (a == 255) ? 512 : 0);
      else for (int j = 0; j < c; j++)
        push(m, 1024 + ((a == 255 && j == c - 1) ? 512 : 0) + a);
    end
  endfunction

  task automatic compare();
    if (rel) cyc++;
    for (int m = 0; m < 2; m++) begin
      int e = 0;
      int qs;
      string mtag = (m == 0) ? "R6" : "R5";
      if (m == 0) begin if (q0.size() > 0) e = q0.pop_front(); qs = q0.size(); end
      else        begin if (q1.size() > 0) e = q1.pop_front(); qs = q1.size(); end
      chk(batch_tag, "out_valid", int'(ov[m]), (e >> 10) & 1);
      if (((e >> 10) & 1) == 1) chk(mtag, "out_data", int'(od[m]), e & 255);
      chk("R7", "done", int'(dn[m]), (e >> 9) & 1);
      begin
        int er = (rel && cyc >= 258 && qs == 0) ? 1 : 0;
        string rtag = (!rel || cyc < 258) ? "R1" : ((er == 0) ? "R2" : "R3");
        chk(rtag, "in_ready", int'(rdy[m]), er);
      end
    end
  endtask

  task automatic accept();
    for (int m = 0; m < 2; m++) begin
      int mx = (m == 0) ? 7 : 1;
      if (rel && in_valid && rdy[m]) begin
        if (cnt[m][in_data] < mx) cnt[m][in_data]++;
        if (in_last) build(m);
      end
    end
  endtask

  task automatic step(bit v, int d, bit l);
    @(negedge clk);
    compare();
    in_valid = v;
    in_data  = 8'(d);
    in_last  = l;
    #1;
    accept();
  endtask

  task automatic wait_ready();
    do step(1'b0, 0, 1'b0); while (!(rdy[0] && rdy[1]));
  endtask

  task automatic send(int vals [$]);
    foreach (vals[i]) step(1'b1, vals[i], i == vals.size() - 1);
  endtask

  initial begin
    for (int m = 0; m < 2; m++) for (int a = 0; a < 256; a++) cnt[m][a] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    repeat (4) step(1'b1, 33, 1'b0);        // R1: offered while in reset
    rst_n = 1'b1;
    rel = 1'b1;
    repeat (30) step(1'b1, 44, 1'b1);       // R2: offered with last during wipe
    wait_ready();
    // R3/R4/R5/R6: mixed batch with repeats and both extremes
    send('{5, 200, 5, 0, 255, 77, 5});
    repeat (10) step(1'b1, 42, 1'b0);       // R2: offered during sweep
    wait_ready();
    batch_tag = "R8";
    // R6: saturation at 7, R7: done with final output at 255
    send('{9, 9, 9, 9, 9, 9, 9, 9, 9, 9, 3, 3, 255, 255});
    wait_ready();
    send('{0});                             // R8: table left empty
    wait_ready();
    begin
      int v [$];
      for (int i = 0; i < 12; i++) v.push_back((i * 37 + 200) % 256);
      v.push_back(200);
      v.push_back(1);
      send(v);
    end
    wait_ready();
    repeat (5) step(1'b0, 0, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20000 * 5);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule